// File: doc/BRIEF.md
# Instruction Cache Miss Fill with First-Beat Forwarding

This block handles an instruction fetch whose target is missing from both the first-level and the second-level cache. After a fixed delay it puts the line-aligned block address on a system bus that runs at half the core clock. It then collects the line as 64-bit beats, each holding two 32-bit instructions, and writes every beat into the instruction cache through a write port. The first beat is also passed to the instruction fetcher in the same cycle as its cache write. Fetch can therefore resume before the rest of the line has arrived.

Core cycles are counted from reset release: the first cycle after reset is cycle 0. A bus cycle is an even core cycle followed by the next odd one. Bus inputs are sampled only on the clock edge that ends an odd cycle. Bus outputs change only at the start of an even cycle. A separate flag reports that a fetch target missed the first-level cache, so the branch-target instruction buffer must treat it as absent too.

Top module: `ifill_fwd`

## Requirements
- R1: A fetch request with `l1_hit` or `l2_hit` set starts no fill: `busy` stays 0 and `bus_req` never rises.
- R2: One cycle after any cycle with `fetch_req`=1 and `l1_hit`=0, `tgt_miss` is 1, whatever `l2_hit` and `busy` are. In every other cycle it is 0.
- R3: `bus_req` rises only in an even core cycle and stays high for exactly two core cycles (one bus cycle).
- R4: A miss is accepted on the edge ending cycle c0. `bus_req` then rises in the first even cycle at or after c0+ADDR_DLY+1. `bus_addr` is the fetch address with its low log2(BEATS*BEAT_W/8) bits (5 by default) cleared.
- R5: Bus cycles that end with `bus_beat_vld`=1 deliver beats in order 0 to BEATS-1, starting with the bus cycle after the address cycle. Bus cycles with `bus_beat_vld`=0 are wait states. Each delivered beat shows as a one-cycle `cache_we`, with `cache_wbeat` equal to its index and `cache_wdata` equal to its data, in the cycle after it is sampled.
- R6: `fetch_vld` is 1 only in the cycle of beat 0's cache write, and `fetch_data` then equals beat 0. It is 1 exactly once per fill.
- R7: `busy` is 1 from the cycle after a miss is accepted up to, but not including, the cycle in which the last beat's write appears. A miss request that arrives while `busy` is 1 is ignored: the address stays the same and no second bus request follows.
- R8: `bus_beat_vld` is ignored in three cases: when it is high only during an even cycle, when it is high during the address cycle, and when no fill is in progress. None of these produces a cache write.
- R9: During reset `busy`, `bus_req`, `cache_we`, `fetch_vld` and `tgt_miss` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch lookup valid this cycle |
| fetch_addr | input | ADDR_W (32) | Fetch target byte address |
| l1_hit | input | 1 | Target present in first-level cache |
| l2_hit | input | 1 | Target present in second-level cache |
| tgt_miss | output | 1 | Target missed first level; treat as absent from branch-target buffer |
| busy | output | 1 | Fill in progress; new misses ignored |
| bus_req | output | 1 | Block read address valid on the bus |
| bus_addr | output | ADDR_W (32) | Line-aligned block address |
| bus_beat_vld | input | 1 | Data beat valid on the bus |
| bus_beat_data | input | BEAT_W (64) | Data beat, two instructions |
| cache_we | output | 1 | Cache line write strobe |
| cache_wbeat | output | log2(BEATS) (2) | Beat index within the line |
| cache_wdata | output | BEAT_W (64) | Beat written to the cache |
| fetch_vld | output | 1 | Forwarded beat valid for the fetcher |
| fetch_data | output | BEAT_W (64) | Forwarded first beat |

## Verification
The hardest situations to reach are the edges of the bus-cycle alignment. These are a miss that lands on either core phase, so the address delay rounds up by a different amount, and a beat valid that lines up badly with the sampling edge. The bench tracks core-cycle parity itself. It sweeps fills started on even and on odd cycles, with zero to two wait-state bus cycles between beats. It also injects valids on the even cycle only, valids during the address cycle, and a second miss while the first is still in its delay. The expected rise cycle, the address and the line contents are all computed from the cycle count and an arithmetic memory model.

// File: rtl/ifill_pkg.sv
package ifill_pkg;
  typedef enum logic [1:0] {
    FS_IDLE,
    FS_WAIT,
    FS_ADDR,
    FS_FILL
  } fill_state_e;
endpackage

// File: rtl/ifill_bus_phase.sv
module ifill_bus_phase #(
  parameter int RATIO = 2
) (
  input  logic clk,
  input  logic rst,
  output logic bus_edge
);
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;

  generate
    if (RATIO < 2) begin : g_same
      assign bus_edge = 1'b1;
    end else begin : g_div
      logic [CW-1:0] ph_cnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          ph_cnt <= '0;
        end else if (ph_cnt == CW'(RATIO - 1)) begin
          ph_cnt <= '0;
        end else begin
          ph_cnt <= ph_cnt + 1'b1;
        end
      end
      // last core cycle of each bus cycle
      assign bus_edge = (ph_cnt == CW'(RATIO - 1));
    end
  endgenerate
endmodule

// File: rtl/ifill_ctrl.sv
module ifill_ctrl
  import ifill_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BEAT_W   = 64,
  parameter int BEATS    = 4,
  parameter int ADDR_DLY = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_edge,
  input  logic                       fetch_req,
  input  logic [ADDR_W-1:0]          fetch_addr,
  input  logic                       l1_hit,
  input  logic                       l2_hit,
  input  logic                       beat_vld,
  output logic                       tgt_miss,
  output logic                       busy,
  output logic                       bus_req,
  output logic [ADDR_W-1:0]          bus_addr,
  output logic                       beat_take,
  output logic [$clog2(BEATS)-1:0]   beat_idx
);
  localparam int BIDX_W = $clog2(BEATS);
  localparam int OFF_W  = $clog2(BEATS * BEAT_W / 8);
  localparam int DCNT_W = $clog2(ADDR_DLY + 1);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((1 << OFF_W) - 1);

  fill_state_e       st;
  logic [DCNT_W-1:0] dly_cnt;
  logic              miss_start;

  assign miss_start = (st == FS_IDLE) && fetch_req && !l1_hit && !l2_hit;
  assign beat_take  = (st == FS_FILL) && bus_edge && beat_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_miss <= 1'b0;
    end else begin
      tgt_miss <= fetch_req && !l1_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= FS_IDLE;
      busy     <= 1'b0;
      bus_req  <= 1'b0;
      bus_addr <= '0;
      dly_cnt  <= '0;
      beat_idx <= '0;
    end else begin
      unique case (st)
        FS_IDLE: begin
          if (miss_start) begin
            st       <= FS_WAIT;
            busy     <= 1'b1;
            bus_addr <= fetch_addr & ~OFF_MASK;
            dly_cnt  <= DCNT_W'(ADDR_DLY - 1);
          end
        end
        FS_WAIT: begin
          if (dly_cnt != '0) begin
            dly_cnt <= dly_cnt - 1'b1;
          end else if (bus_edge) begin
            st      <= FS_ADDR;
            bus_req <= 1'b1;
          end
        end
        FS_ADDR: begin
          if (bus_edge) begin
            st       <= FS_FILL;
            bus_req  <= 1'b0;
            beat_idx <= '0;
          end
        end
        FS_FILL: begin
          if (beat_take) begin
            beat_idx <= beat_idx + 1'b1;
            if (beat_idx == BIDX_W'(BEATS - 1)) begin
              st   <= FS_IDLE;
              busy <= 1'b0;
            end
          end
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

  // R1
  hit_no_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && fetch_req && (l1_hit || l2_hit)) |=> !busy);

  // R7
  busy_keeps_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && fetch_req) |=> $stable(bus_addr));

  // R3
  req_full_bus_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |=> bus_req);

  // R3
  req_on_bus_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> $past(bus_edge));
endmodule

// File: rtl/ifill_beat_path.sv
module ifill_beat_path #(
  parameter int BEAT_W = 64,
  parameter int BEATS  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     beat_take,
  input  logic [$clog2(BEATS)-1:0] beat_idx,
  input  logic [BEAT_W-1:0]        beat_data,
  output logic                     cache_we,
  output logic [$clog2(BEATS)-1:0] cache_wbeat,
  output logic [BEAT_W-1:0]        cache_wdata,
  output logic                     fetch_vld,
  output logic [BEAT_W-1:0]        fetch_data
);
  logic first_beat;
  assign first_beat = beat_take && (beat_idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cache_we    <= 1'b0;
      cache_wbeat <= '0;
      cache_wdata <= '0;
      fetch_vld   <= 1'b0;
      fetch_data  <= '0;
    end else begin
      cache_we  <= beat_take;
      fetch_vld <= first_beat;
      if (beat_take) begin
        cache_wbeat <= beat_idx;
        cache_wdata <= beat_data;
      end
      if (first_beat) begin
        fetch_data <= beat_data;
      end
    end
  end
endmodule

// File: rtl/ifill_fwd.sv
module ifill_fwd #(
  parameter int ADDR_W   = 32,
  parameter int BEAT_W   = 64,
  parameter int BEATS    = 4,
  parameter int ADDR_DLY = 5,
  parameter int RATIO    = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fetch_req,
  input  logic [ADDR_W-1:0]        fetch_addr,
  input  logic                     l1_hit,
  input  logic                     l2_hit,
  output logic                     tgt_miss,
  output logic                     busy,
  output logic                     bus_req,
  output logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_beat_vld,
  input  logic [BEAT_W-1:0]        bus_beat_data,
  output logic                     cache_we,
  output logic [$clog2(BEATS)-1:0] cache_wbeat,
  output logic [BEAT_W-1:0]        cache_wdata,
  output logic                     fetch_vld,
  output logic [BEAT_W-1:0]        fetch_data
);
  localparam int BIDX_W = $clog2(BEATS);

  logic              bus_edge;
  logic              beat_take;
  logic [BIDX_W-1:0] beat_idx;

  ifill_bus_phase #(.RATIO(RATIO)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .bus_edge (bus_edge)
  );

  ifill_ctrl #(
    .ADDR_W   (ADDR_W),
    .BEAT_W   (BEAT_W),
    .BEATS    (BEATS),
    .ADDR_DLY (ADDR_DLY)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .bus_edge   (bus_edge),
    .fetch_req  (fetch_req),
    .fetch_addr (fetch_addr),
    .l1_hit     (l1_hit),
    .l2_hit     (l2_hit),
    .beat_vld   (bus_beat_vld),
    .tgt_miss   (tgt_miss),
    .busy       (busy),
    .bus_req    (bus_req),
    .bus_addr   (bus_addr),
    .beat_take  (beat_take),
    .beat_idx   (beat_idx)
  );

  ifill_beat_path #(
    .BEAT_W (BEAT_W),
    .BEATS  (BEATS)
  ) u_path (
    .clk         (clk),
    .rst         (rst),
    .beat_take   (beat_take),
    .beat_idx    (beat_idx),
    .beat_data   (bus_beat_data),
    .cache_we    (cache_we),
    .cache_wbeat (cache_wbeat),
    .cache_wdata (cache_wdata),
    .fetch_vld   (fetch_vld),
    .fetch_data  (fetch_data)
  );

  // R6
  fwd_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_vld |-> (cache_we && cache_wbeat == '0));

  // R7
  write_during_fill_chk: assert property (@(posedge clk) disable iff (rst)
    cache_we |-> $past(busy));
endmodule

// File: tb/test_ifill_fwd.sv
module test_ifill_fwd;
  localparam int ADDR_DLY = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_req = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        l1_hit = 1'b0;
  logic        l2_hit = 1'b0;
  logic        tgt_miss, busy, bus_req;
  logic [31:0] bus_addr;
  logic        bus_beat_vld = 1'b0;
  logic [63:0] bus_beat_data = '0;
  logic        cache_we, fetch_vld;
  logic [1:0]  cache_wbeat;
  logic [63:0] cache_wdata, fetch_data;

  always #2 clk = ~clk;

  ifill_fwd #(.ADDR_DLY(ADDR_DLY)) i_ifill_fwd (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .l1_hit(l1_hit), .l2_hit(l2_hit), .tgt_miss(tgt_miss), .busy(busy),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_beat_vld(bus_beat_vld),
    .bus_beat_data(bus_beat_data), .cache_we(cache_we), .cache_wbeat(cache_wbeat),
    .cache_wdata(cache_wdata), .fetch_vld(fetch_vld), .fetch_data(fetch_data)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, wd = 0;
  int wr_cnt = 0, fwd_cnt = 0, req_rises = 0, exp_idx = 0;
  logic [31:0] cur_line = '0;
  logic [63:0] line_got [4];
  logic prev_busy = 1'b0, prev_req = 1'b0;
  bit done = 1'b0;

  function automatic logic [63:0] beat_val(input logic [31:0] line, input int idx);
    logic [31:0] a;
    a = line + 32'(idx * 8);
    return {~(a + 32'd4), a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else cyc <= cyc + 1;
  end

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 100000 && !done) begin
      done = 1'b1;
      chk(1'b0, "watchdog", 64'(wd), 64'd100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // monitor of cache write and forward ports
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_req && !prev_req) req_rises++;
      if (cache_we) begin
        chk(cache_wbeat == 2'(exp_idx), "R5 beat order", 64'(cache_wbeat), 64'(exp_idx));
        chk(cache_wdata == beat_val(cur_line, int'(cache_wbeat)), "R5 beat data",
            cache_wdata, beat_val(cur_line, int'(cache_wbeat)));
        line_got[cache_wbeat] = cache_wdata;
        if (cache_wbeat == 2'd3)
          chk(!busy && prev_busy, "R7 busy falls with last write", 64'({prev_busy, busy}), 64'b10);
        exp_idx++;
        wr_cnt++;
      end
      if (fetch_vld) begin
        fwd_cnt++;
        chk(cache_we && cache_wbeat == 2'd0, "R6 forward with beat 0 write",
            64'({cache_we, cache_wbeat}), 64'b100);
        chk(fetch_data == beat_val(cur_line, 0), "R6 forward data",
            fetch_data, beat_val(cur_line, 0));
      end
      prev_busy = busy;
      prev_req  = bus_req;
    end
  end

  // mode: 0 plain, 1 valid during address cycle, 2 valid on even cycle only,
  // 3 second miss during delay
  task automatic do_fill(input logic [31:0] addr, input int gaps, input int parity,
                         input int mode);
    int c0, exp_r, wr0, fw0, rq0;
    @(negedge clk);
    if ((cyc % 2) != parity) @(negedge clk);
    c0 = cyc;
    cur_line = addr & ~32'd31;
    exp_idx = 0;
    wr0 = wr_cnt; fw0 = fwd_cnt; rq0 = req_rises;
    fetch_req = 1'b1; fetch_addr = addr; l1_hit = 1'b0; l2_hit = 1'b0;
    @(negedge clk);
    fetch_req = 1'b0;
    chk(busy == 1'b1, "R7 busy rises after miss", 64'(busy), 64'd1);
    chk(tgt_miss == 1'b1, "R2 target miss flag", 64'(tgt_miss), 64'd1);
    if (mode == 3) begin
      fetch_req = 1'b1; fetch_addr = addr ^ 32'h0000_1000;
    end
    @(negedge clk);
    fetch_req = 1'b0;
    exp_r = c0 + ADDR_DLY + 1;
    if (exp_r % 2 != 0) exp_r++;
    while (!bus_req) @(negedge clk);
    chk(cyc == exp_r, "R4 address timing", 64'(cyc), 64'(exp_r));
    chk(bus_addr == cur_line, "R4 line-aligned address", 64'(bus_addr), 64'(cur_line));
    chk(cyc % 2 == 0, "R3 request starts on even cycle", 64'(cyc % 2), 64'd0);
    if (mode == 1) begin
      bus_beat_vld = 1'b1; bus_beat_data = '1;
    end
    @(negedge clk);
    chk(bus_req == 1'b1, "R3 request held second cycle", 64'(bus_req), 64'd1);
    @(negedge clk);
    bus_beat_vld = 1'b0;
    chk(bus_req == 1'b0, "R3 request two cycles only", 64'(bus_req), 64'd0);
    if (mode == 2) begin
      bus_beat_vld = 1'b1; bus_beat_data = 64'hdead_beef_dead_beef;
    end
    @(negedge clk);
    bus_beat_vld = 1'b0;
    @(negedge clk);
    chk(wr_cnt == wr0, "R8 misaligned or early valid ignored", 64'(wr_cnt - wr0), 64'd0);
    for (int b = 0; b < 4; b++) begin
      repeat (2 * gaps) @(negedge clk);
      bus_beat_vld = 1'b1; bus_beat_data = beat_val(cur_line, b);
      @(negedge clk);
      @(negedge clk);
      bus_beat_vld = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(wr_cnt - wr0 == 4, "R5 four writes per line", 64'(wr_cnt - wr0), 64'd4);
    chk(fwd_cnt - fw0 == 1, "R6 one forward per fill", 64'(fwd_cnt - fw0), 64'd1);
    for (int b = 0; b < 4; b++)
      chk(line_got[b] == beat_val(cur_line, b), "R5 full line compare",
          line_got[b], beat_val(cur_line, b));
    chk(busy == 1'b0, "R7 idle after fill", 64'(busy), 64'd0);
    if (mode == 3) repeat (ADDR_DLY + 6) @(negedge clk);
    chk(req_rises - rq0 == 1, "R7 one bus request per fill", 64'(req_rises - rq0), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !bus_req && !cache_we && !fetch_vld && !tgt_miss, "R9 reset outputs",
        64'({busy, bus_req, cache_we, fetch_vld, tgt_miss}), 64'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // hit combinations: no fill
    for (int h = 1; h < 4; h++) begin
      int rq0;
      rq0 = req_rises;
      fetch_req = 1'b1; fetch_addr = 32'h0000_4000 + 32'(h * 64);
      l1_hit = h[0]; l2_hit = h[1];
      @(negedge clk);
      fetch_req = 1'b0;
      chk(busy == 1'b0, "R1 hit starts no fill", 64'(busy), 64'd0);
      chk(tgt_miss == !h[0], "R2 target miss follows first level",
          64'(tgt_miss), 64'(!h[0]));
      @(negedge clk);
      chk(tgt_miss == 1'b0, "R2 flag clears", 64'(tgt_miss), 64'd0);
      repeat (ADDR_DLY + 6) @(negedge clk);
      chk(req_rises == rq0 && !busy, "R1 no bus request on hit",
          64'(req_rises - rq0), 64'd0);
    end
    l1_hit = 1'b0; l2_hit = 1'b0;

    // valid while idle
    begin
      int wr0;
      wr0 = wr_cnt;
      if (cyc % 2 != 0) @(negedge clk);
      bus_beat_vld = 1'b1; bus_beat_data = 64'h1234;
      repeat (2) @(negedge clk);
      bus_beat_vld = 1'b0;
      repeat (2) @(negedge clk);
      chk(wr_cnt == wr0 && !busy, "R8 valid while idle ignored", 64'(wr_cnt - wr0), 64'd0);
    end

    // sweep: start parity x wait states x address
    for (int p = 0; p < 2; p++)
      for (int g = 0; g < 3; g++)
        for (int a = 0; a < 3; a++)
          do_fill(32'h1000_0000 + 32'(a * 32'h0001_2344) + 32'(g * 8) + 32'(p * 4), g, p, 0);

    for (int m = 1; m < 4; m++) begin
      do_fill(32'h2000_0010 + 32'(m * 32'h100), 1, 0, m);
      do_fill(32'h3000_001c + 32'(m * 32'h100), 0, 1, m);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule